// File: doc/BRIEF.md
# Predicate Stream Compaction Unit

This block packs a fixed vector of data lanes. Each lane carries a one-bit keep flag. Lanes whose flag is 1 are kept and all others are dropped. The kept lanes are written to the low slots of an output vector in the same relative order they had on input. The unit loads the whole vector in parallel on a start strobe. It then does the job in two phases. The first phase is an exclusive prefix sum over the keep flags, which gives every kept lane its destination slot. The second phase is a single scatter that writes each kept lane to that slot.

A small state machine runs the sequence. In S_IDLE the unit waits for start. The *accept* transition (start high) captures the lanes and flags and moves to S_SCAN. S_SCAN runs log2(N) doubling steps of an inclusive sum, one step per clock. The *step* transition stays in S_SCAN. The *finish-scan* transition moves to S_SCATTER after the last step. The *write* transition registers the packed vector and the valid count and moves to S_DONE. S_DONE raises done for one cycle, and the *release* transition returns to S_IDLE. For example, flags 1,0,1,1,0,0,1,0 on lanes A..H give slot addresses 0,1,1,2,3,3,3,4 and the packed output A,C,D,G with a count of 4.

Top module: `stream_packer`

## Requirements
- R1: After reset, out_data is all zero, out_count is 0 and done is low.
- R2: Lane i is at in_data[i*DATA_W +: DATA_W] and its flag is in_keep[i], where 1 means keep. A kept lane i appears in output slot k, located at out_data[k*DATA_W +: DATA_W], where k is the number of kept lanes with an index below i. Kept lanes therefore keep their input order.
- R3: out_count equals the number of set bits in in_keep. This is the exclusive sum of the last lane plus that lane's flag.
- R4: Every output slot with an index at or beyond out_count reads zero when done is high, even when an earlier run filled that slot.
- R5: A lane whose flag is 0 never appears in any output slot.
- R6: done goes high during the log2(LANES)+2nd cycle after the clock edge that accepts start, and it stays high for exactly one cycle.
- R7: start is ignored unless the unit is in S_IDLE. A strobe sent while a run is in progress changes neither that run's result nor its timing.
- R8: out_data and out_count change only on the edge that raises done. Between runs they hold their values whatever in_data and in_keep do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load strobe; sampled in S_IDLE only |
| in_data | input | LANES*DATA_W | Input lanes, lane i at bits i*DATA_W and up |
| in_keep | input | LANES | Keep flag per lane, 1 = keep |
| out_data | output | LANES*DATA_W | Packed output slots |
| out_count | output | $clog2(LANES+1) | Number of valid output slots |
| done | output | 1 | One-cycle pulse when the outputs are updated |

## Verification
All 256 keep patterns of an 8-lane build are applied. Each lane carries a distinct nonzero value, so a wrong slot address, a reordered pair or a leaked dropped lane each shows up as a mismatch in a specific slot. The all-ones and all-zeros patterns exercise the full count and the empty result. Running a sparse pattern straight after a dense one shows whether stale slots are cleared. A start pulse in the middle of a run and input changes between runs show whether the unit ignores start while busy and holds its outputs.

// File: rtl/stream_pack_pkg.sv
package stream_pack_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_SCAN    = 2'd1,
        S_SCATTER = 2'd2,
        S_DONE    = 2'd3
    } pack_state_t;
endpackage

// File: rtl/pack_prefix_scan.sv
// Inclusive sum of keep flags, one doubling step per advance.
module pack_prefix_scan #(
    parameter int N    = 8,
    parameter int CW   = 4,
    parameter int LOGN = 3,
    parameter int SW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            advance,
    input  logic [SW-1:0]   stage,
    input  logic [N-1:0]    keep,
    output logic [N*CW-1:0] incl
);
    logic [CW-1:0] acc     [N];
    logic [CW-1:0] acc_nxt [N];
    logic [CW-1:0] partner [N][LOGN];

    for (genvar i = 0; i < N; i++) begin : g_lane
        for (genvar s = 0; s < LOGN; s++) begin : g_step
            if (i >= (1 << s)) begin : g_src
                assign partner[i][s] = acc[i - (1 << s)];
            end else begin : g_none
                assign partner[i][s] = '0;
            end
        end

        always_comb begin
            acc_nxt[i] = acc[i];
            for (int s = 0; s < LOGN; s++) begin
                if (stage == SW'(s)) acc_nxt[i] = acc[i] + partner[i][s];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n)       acc[i] <= '0;
            else if (load)    acc[i] <= CW'(keep[i]);
            else if (advance) acc[i] <= acc_nxt[i];
        end

        assign incl[i*CW +: CW] = acc[i];
    end
endmodule

// File: rtl/pack_scatter.sv
// Writes each kept lane into the slot named by its exclusive sum.
module pack_scatter #(
    parameter int N  = 8,
    parameter int W  = 8,
    parameter int CW = 4
) (
    input  logic [N*W-1:0]  data,
    input  logic [N-1:0]    keep,
    input  logic [N*CW-1:0] excl,
    output logic [N*W-1:0]  packed_out
);
    always_comb begin
        packed_out = '0;
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                if (keep[i] && excl[i*CW +: CW] == CW'(j))
                    packed_out[j*W +: W] = data[i*W +: W];
            end
        end
    end
endmodule

// File: rtl/stream_packer.sv
module stream_packer #(
    parameter int LANES  = 8,
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [LANES*DATA_W-1:0]   in_data,
    input  logic [LANES-1:0]          in_keep,
    output logic [LANES*DATA_W-1:0]   out_data,
    output logic [$clog2(LANES+1)-1:0] out_count,
    output logic                      done
);
    import stream_pack_pkg::*;

    localparam int CW   = $clog2(LANES + 1);
    localparam int LOGN = $clog2(LANES);
    localparam int SW   = (LOGN > 1) ? $clog2(LOGN) : 1;

    pack_state_t           state, state_nxt;
    logic [SW-1:0]         step_q;
    logic [LANES*DATA_W-1:0] data_q;
    logic [LANES-1:0]      keep_q;
    logic [LANES*CW-1:0]   incl;
    logic [LANES*CW-1:0]   excl;
    logic [LANES*DATA_W-1:0] packed_w;
    logic                  last_step;

    assign last_step = (step_q == SW'(LOGN - 1));

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:    if (start) state_nxt = S_SCAN;
            S_SCAN:    if (last_step) state_nxt = S_SCATTER;
            S_SCATTER: state_nxt = S_DONE;
            S_DONE:    state_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q    <= '0;
            data_q    <= '0;
            keep_q    <= '0;
            out_data  <= '0;
            out_count <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    step_q <= '0;
                    if (start) begin
                        data_q <= in_data;
                        keep_q <= in_keep;
                    end
                end
                S_SCAN:    step_q <= step_q + SW'(1);
                S_SCATTER: begin
                    out_data  <= packed_w;
                    out_count <= incl[(LANES-1)*CW +: CW];
                end
                S_DONE:    step_q <= '0;
            endcase
        end
    end

    assign done = (state == S_DONE);

    for (genvar i = 0; i < LANES; i++) begin : g_excl
        assign excl[i*CW +: CW] = incl[i*CW +: CW] - CW'(keep_q[i]);
    end

    pack_prefix_scan #(.N(LANES), .CW(CW), .LOGN(LOGN), .SW(SW)) scan_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state == S_IDLE && start),
        .advance (state == S_SCAN),
        .stage   (step_q),
        .keep    (in_keep),
        .incl    (incl)
    );

    pack_scatter #(.N(LANES), .W(DATA_W), .CW(CW)) scatter_i (
        .data       (data_q),
        .keep       (keep_q),
        .excl       (excl),
        .packed_out (packed_w)
    );
endmodule

// File: rtl/stream_packer_chk.sv
module stream_packer_chk #(
    parameter int N    = 8,
    parameter int W    = 8,
    parameter int CW   = 4,
    parameter int LOGN = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          done,
    input logic [N*W-1:0] out_data,
    input logic [CW-1:0] out_count
);
    localparam int LAT = LOGN + 1;

    logic       active;
    logic [7:0] since;
    logic       tail_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            since  <= '0;
        end else if (!active && start) begin
            active <= 1'b1;
            since  <= '0;
        end else if (active) begin
            if (done) active <= 1'b0;
            else      since  <= since + 8'd1;
        end
    end

    always_comb begin
        tail_ok = 1'b1;
        for (int j = 0; j < N; j++) begin
            if (CW'(j) >= out_count && out_data[j*W +: W] != '0) tail_ok = 1'b0;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $fell(rst_n) |=> (out_count == '0 && !done));

    // R3
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> out_count <= CW'(N));

    // R4
    tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> tail_ok);

    // R6
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (active && since == 8'(LAT)));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_data) |-> done);

    // R8
    hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_count) |-> done);
endmodule

bind stream_packer stream_packer_chk #(
    .N(LANES), .W(DATA_W), .CW(CW), .LOGN(LOGN)
) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .out_data(out_data), .out_count(out_count)
);

// File: tb/stream_packer_tb_top.sv
`timescale 1ns/1ps
module stream_packer_tb_top;
    localparam int N    = 8;
    localparam int W    = 8;
    localparam int CW   = $clog2(N + 1);
    localparam int LOGN = $clog2(N);
    localparam int LAT  = LOGN + 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N*W-1:0] in_data = '0;
    logic [N-1:0]   in_keep = '0;
    logic [N*W-1:0] out_data;
    logic [CW-1:0]  out_count;
    logic           done;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    stream_packer #(.LANES(N), .DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .in_data(in_data),
        .in_keep(in_keep), .out_data(out_data), .out_count(out_count),
        .done(done)
    );

    function automatic logic [N*W-1:0] make_data(int seed);
        logic [N*W-1:0] d;
        for (int i = 0; i < N; i++) d[i*W +: W] = W'(((i + 1) << 4) | (seed & 15));
        return d;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Run one vector; optional disturb pulses start mid-run with other inputs.
    task automatic run(logic [N-1:0] keep, logic [N*W-1:0] data, bit disturb);
        int wait_n;
        int slot;
        logic [N*W-1:0] exp_data;
        @(negedge clk);
        in_keep = keep; in_data = data; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_n = 0;
        while (!done && wait_n < 50) begin
            if (disturb && wait_n == 1) begin
                in_keep = ~keep; in_data = ~data; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            wait_n++;
        end
        start = 1'b0;
        // R6 / R7: done in the expected cycle
        check(done && wait_n == LAT, disturb ? "R7" : "R6", wait_n, LAT);
        exp_data = '0;
        slot = 0;
        for (int i = 0; i < N; i++) begin
            if (keep[i]) begin
                exp_data[slot*W +: W] = data[i*W +: W];
                slot++;
            end
        end
        // R3
        check(out_count == CW'(slot), disturb ? "R7" : "R3", int'(out_count), slot);
        for (int j = 0; j < N; j++) begin
            // R2 for slots below count, R4 for the rest
            check(out_data[j*W +: W] == exp_data[j*W +: W],
                  disturb ? "R7" : (j < slot ? "R2" : "R4"),
                  int'(out_data[j*W +: W]), int'(exp_data[j*W +: W]));
        end
        // R5: no dropped lane value in any slot
        for (int i = 0; i < N; i++) begin
            if (!keep[i]) begin
                for (int j = 0; j < N; j++) begin
                    check(out_data[j*W +: W] != data[i*W +: W], "R5",
                          int'(out_data[j*W +: W]), 0);
                end
            end
        end
        @(negedge clk);
        // R6: single-cycle pulse
        check(!done, "R6", int'(done), 0);
    endtask

    initial begin
        logic [N*W-1:0] held_d;
        logic [CW-1:0]  held_c;
        repeat (3) @(negedge clk);
        // R1
        check(out_data == '0, "R1", int'(out_data[31:0]), 0);
        check(out_count == '0, "R1", int'(out_count), 0);
        check(!done, "R1", int'(done), 0);
        rst_n = 1'b1;

        for (int p = 0; p < (1 << N); p++) run(N'(p), make_data(p), 1'b0);

        // R4: sparse after dense clears stale slots
        run('1, make_data(3), 1'b0);
        run(8'b0000_0001, make_data(5), 1'b0);
        run('1, make_data(7), 1'b0);
        run('0, make_data(9), 1'b0);

        // R7: start mid-run ignored
        run(8'b1011_0010, make_data(11), 1'b1);
        run(8'b0100_1101, make_data(12), 1'b1);

        // R8: outputs hold while inputs change without start
        held_d = out_data; held_c = out_count;
        for (int k = 0; k < 5; k++) begin
            in_data = make_data(k + 20); in_keep = N'(k * 37);
            @(negedge clk);
            check(out_data == held_d && out_count == held_c, "R8",
                  int'(out_count), int'(held_c));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule